// File: doc/BRIEF.md
# Instruction Fetch Region Tracker

This block follows a processor core's program flow at the granularity of memory targets. Each time the core takes a branch, it presents the jump address with a one-cycle strobe. The tracker decodes the top address byte into a fetch target, the address mask for that target and four prefetch wait counts, and registers all of them. The fetch datapath then reads these registered values until the next branch: the sequential and non-sequential waits for halfword and word fetches.

One tracker serves either of two core flavours, chosen by `main_mode`. The main core has tightly coupled instruction RAM whose usable window depends on a size field. The secondary core has a working RAM that is split between a private bank and a shared bank. Some jumps go to a region the active core cannot execute from, or fail the instruction RAM range check. Such a jump is marked with region code -1 and raises a one-cycle fault pulse. Fetches are then redirected to a fixed illegal-instruction word with a zero mask. A jump to an unloaded boot ROM is also redirected to that word, but raises no fault.

Top module: `fetch_region_tracker`

## Requirements
- R1: While reset is asserted and after its release, until the first branch, the outputs are: region 0, mask 0, target code 0 (none), trap off, fault off, and all four wait counts 0.
- R2: A branch strobed in cycle N updates every output at the clock edge that ends cycle N. With no strobe, target, region, mask and counts hold their values.
- R3: A jump into region byte 0x02 selects target code 2 (main RAM) with mask 0x003FFFFF in both modes. The region output is {0, addr[31:24]} for every valid or trap-without-fault jump.
- R4: In main mode, region bytes 0x00 and 0x01 select target code 1 (instruction RAM) with mask 0x00007FFF, but only if the full address is below 512 << tcm_vsize. Otherwise the jump is invalid.
- R5: In secondary mode, region byte 0x03 selects the private bank (code 3, mask 0x0000FFFF) when the address is at or above 0x03800000 or when shared_sel is 0. Otherwise it selects the shared bank (code 4) with mask (0x2000 << shared_sel) - 1.
- R6: The boot ROM region is byte 0xFF in main mode and byte 0x00 in secondary mode. With rom_present high it selects code 5 with mask 0x00000FFF. With rom_present low it gives code 6 (trap), mask 0 and trap on, keeps the region byte, and raises no fault.
- R7: In main mode, an invalid jump is any region byte other than 0x00, 0x01, 0x02 and 0xFF, or a failed range check. In secondary mode it is any byte other than 0x00, 0x02 and 0x03. An invalid jump gives region 0x1FF (-1), code 6, mask 0 and trap on. jump_fault is high only in the cycle after each invalid strobe.
- R8: trap_opcode is 0xE710B710 while trap_fetch is high and 0 otherwise.
- R9: In main mode, a non-faulting jump to region byte r < 8 gives non-sequential waits {6,6,17,6,6,7,7,6}[r] for halfwords and {6,6,19,6,6,9,9,6}[r] for words, indexed from r = 0. The sequential waits equal the non-sequential ones. All four are 0 when r >= 8.
- R10: In secondary mode, a non-faulting jump to r < 8 gives these waits, indexed from r = 0: halfword non-sequential {0,0,8,0,0,0,0,0}, word non-sequential {0,0,9,0,0,1,1,0}, halfword sequential {0,0,1,0,0,0,0,0}, word sequential {0,0,2,0,0,1,1,0}.
- R11: An invalid jump leaves all four counts unchanged in main mode and clears them to 0 in secondary mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | One-cycle strobe for a taken branch |
| br_addr | input | 32 | Jump target address |
| main_mode | input | 1 | 1 selects main-core decoding and tables, 0 secondary |
| rom_present | input | 1 | Boot ROM image is loaded |
| tcm_vsize | input | 5 | Instruction RAM size field, window is 512 << value |
| shared_sel | input | 2 | Shared working RAM size code, 0 means none |
| fetch_target | output | 3 | Registered target code |
| fetch_region | output | 9 | Registered region, 0x1FF for invalid |
| fetch_mask | output | 32 | Registered address mask for the target |
| trap_fetch | output | 1 | Fetches return the illegal-instruction word |
| trap_opcode | output | 32 | Illegal-instruction word while trapping, else 0 |
| jump_fault | output | 1 | One-cycle pulse after an invalid jump |
| wait_nseq16 | output | 5 | Non-sequential halfword prefetch wait |
| wait_seq16 | output | 5 | Sequential halfword prefetch wait |
| wait_nseq32 | output | 5 | Non-sequential word prefetch wait |
| wait_seq32 | output | 5 | Sequential word prefetch wait |

## Verification
Every output passes through a single register stage. A strobe driven in one cycle therefore shows up exactly one edge later, and trap_opcode follows trap_fetch in the same cycle. The bench drives inputs on the falling edge and advances its behavioural model on the rising edge, so model and design move in step. It compares every output on each falling edge, half a cycle after the edge that loaded them. The branch sequences include back-to-back strobes, faults that follow one another, and changes of mode between branches. These show that values are held between strobes and that jump_fault lasts only one cycle.

// File: rtl/fetch_region_pkg.sv
package fetch_region_pkg;

  typedef enum logic [2:0] {
    TGT_NONE  = 3'd0,
    TGT_IRAM  = 3'd1,
    TGT_MAIN  = 3'd2,
    TGT_WPRIV = 3'd3,
    TGT_WSHR  = 3'd4,
    TGT_ROM   = 3'd5,
    TGT_TRAP  = 3'd6
  } fetch_tgt_e;

  localparam logic [31:0] TRAP_WORD = 32'hE710B710;
  localparam logic [8:0]  REGION_BAD = 9'h1FF;

  // count slot order: bit0 = sequential, bit1 = word width
  localparam int K_NSEQ16 = 0;
  localparam int K_SEQ16  = 1;
  localparam int K_NSEQ32 = 2;
  localparam int K_SEQ32  = 3;
  localparam int N_KINDS  = 4;

  typedef struct packed {
    fetch_tgt_e  tgt;
    logic [8:0]  region;
    logic [31:0] mask;
    logic        trap;
    logic        fault;
    logic        keep_counts;
  } decode_t;

  // Main core: sequential cost equals non-sequential cost.
  function automatic logic [7:0] main_wait(input logic [7:0] rg, input logic wide);
    logic [7:0] w;
    if (rg > 8'd7)                      w = 8'd0;
    else if (rg == 8'd2)                w = wide ? 8'd19 : 8'd17;
    else if (rg == 8'd5 || rg == 8'd6)  w = wide ? 8'd9 : 8'd7;
    else                                w = 8'd6;
    return w;
  endfunction

  function automatic logic [7:0] sub_wait(input logic [7:0] rg, input logic wide,
                                          input logic seq);
    logic [7:0] w;
    if (rg == 8'd2) begin
      case ({wide, seq})
        2'b00:   w = 8'd8;
        2'b01:   w = 8'd1;
        2'b10:   w = 8'd9;
        default: w = 8'd2;
      endcase
    end else if ((rg == 8'd5 || rg == 8'd6) && wide) begin
      w = 8'd1;
    end else begin
      w = 8'd0;
    end
    return w;
  endfunction

  function automatic logic [31:0] shared_mask(input logic [1:0] sel, input int grain);
    return (32'(grain) << sel) - 32'd1;
  endfunction

endpackage

// File: rtl/fetch_target_decode.sv
module fetch_target_decode
  import fetch_region_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int IRAM_BYTES   = 32768,
  parameter int MAIN_BYTES   = 4194304,
  parameter int PRIV_BYTES   = 65536,
  parameter int ROM_BYTES    = 4096,
  parameter int TCM_GRAIN    = 512,
  parameter int SHARED_GRAIN = 8192,
  parameter logic [ADDR_W-1:0] PRIV_SPLIT = 32'h0380_0000,
  parameter logic [7:0] RG_IRAM   = 8'h00,
  parameter logic [7:0] RG_IRAM_M = 8'h01,
  parameter logic [7:0] RG_MAIN   = 8'h02,
  parameter logic [7:0] RG_WRAM   = 8'h03,
  parameter logic [7:0] RG_ROM_MAIN = 8'hFF,
  parameter logic [7:0] RG_ROM_SUB  = 8'h00
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              main_mode_i,
  input  logic              rom_present_i,
  input  logic [4:0]        tcm_vsize_i,
  input  logic [1:0]        shared_sel_i,
  output decode_t           dec_o
);
  localparam logic [31:0] IRAM_MASK = 32'(IRAM_BYTES - 1);
  localparam logic [31:0] MAIN_MASK = 32'(MAIN_BYTES - 1);
  localparam logic [31:0] PRIV_MASK = 32'(PRIV_BYTES - 1);
  localparam logic [31:0] ROM_MASK  = 32'(ROM_BYTES - 1);

  logic [7:0]  rg;
  logic [63:0] tcm_limit;
  logic        in_tcm;

  assign rg        = addr_i[ADDR_W-1 -: 8];
  assign tcm_limit = 64'(TCM_GRAIN) << tcm_vsize_i;
  assign in_tcm    = 64'(addr_i) < tcm_limit;

  always_comb begin
    dec_o.tgt         = TGT_TRAP;
    dec_o.region      = REGION_BAD;
    dec_o.mask        = '0;
    dec_o.trap        = 1'b1;
    dec_o.fault       = 1'b1;
    dec_o.keep_counts = main_mode_i;
    if (main_mode_i) begin
      if ((rg == RG_IRAM || rg == RG_IRAM_M) && in_tcm) begin
        dec_o.tgt = TGT_IRAM; dec_o.mask = IRAM_MASK;
        dec_o.trap = 1'b0;    dec_o.fault = 1'b0;
      end else if (rg == RG_MAIN) begin
        dec_o.tgt = TGT_MAIN; dec_o.mask = MAIN_MASK;
        dec_o.trap = 1'b0;    dec_o.fault = 1'b0;
      end else if (rg == RG_ROM_MAIN) begin
        dec_o.fault = 1'b0;
        if (rom_present_i) begin
          dec_o.tgt = TGT_ROM; dec_o.mask = ROM_MASK; dec_o.trap = 1'b0;
        end
      end
    end else begin
      if (rg == RG_ROM_SUB) begin
        dec_o.fault = 1'b0;
        if (rom_present_i) begin
          dec_o.tgt = TGT_ROM; dec_o.mask = ROM_MASK; dec_o.trap = 1'b0;
        end
      end else if (rg == RG_MAIN) begin
        dec_o.tgt = TGT_MAIN; dec_o.mask = MAIN_MASK;
        dec_o.trap = 1'b0;    dec_o.fault = 1'b0;
      end else if (rg == RG_WRAM) begin
        dec_o.trap = 1'b0; dec_o.fault = 1'b0;
        if (addr_i >= PRIV_SPLIT || shared_sel_i == 2'd0) begin
          dec_o.tgt = TGT_WPRIV; dec_o.mask = PRIV_MASK;
        end else begin
          dec_o.tgt  = TGT_WSHR;
          dec_o.mask = shared_mask(shared_sel_i, SHARED_GRAIN);
        end
      end
    end
    if (!dec_o.fault) dec_o.region = {1'b0, rg};
  end
endmodule

// File: rtl/fetch_wait_lookup.sv
module fetch_wait_lookup
  import fetch_region_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [7:0]                     region_i,
  input  logic                           main_mode_i,
  output logic [N_KINDS-1:0][CNT_W-1:0]  cnt_o
);
  for (genvar k = 0; k < N_KINDS; k++) begin : g_kind
    localparam logic WIDE = ((k / 2) == 1);
    localparam logic SEQ  = ((k % 2) == 1);
    logic [7:0] main_w;
    logic [7:0] sub_w;
    assign main_w   = main_wait(region_i, WIDE);
    assign sub_w    = sub_wait(region_i, WIDE, SEQ);
    assign cnt_o[k] = main_mode_i ? main_w[CNT_W-1:0] : sub_w[CNT_W-1:0];
  end
endmodule

// File: rtl/fetch_region_tracker.sv
module fetch_region_tracker
  import fetch_region_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int CNT_W        = 5,
  parameter int IRAM_BYTES   = 32768,
  parameter int MAIN_BYTES   = 4194304,
  parameter int PRIV_BYTES   = 65536,
  parameter int ROM_BYTES    = 4096,
  parameter int TCM_GRAIN    = 512,
  parameter int SHARED_GRAIN = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_valid,
  input  logic [ADDR_W-1:0] br_addr,
  input  logic              main_mode,
  input  logic              rom_present,
  input  logic [4:0]        tcm_vsize,
  input  logic [1:0]        shared_sel,
  output logic [2:0]        fetch_target,
  output logic [8:0]        fetch_region,
  output logic [31:0]       fetch_mask,
  output logic              trap_fetch,
  output logic [31:0]       trap_opcode,
  output logic              jump_fault,
  output logic [CNT_W-1:0]  wait_nseq16,
  output logic [CNT_W-1:0]  wait_seq16,
  output logic [CNT_W-1:0]  wait_nseq32,
  output logic [CNT_W-1:0]  wait_seq32
);
  decode_t                        dec;
  logic [N_KINDS-1:0][CNT_W-1:0]  lookup;
  logic [N_KINDS-1:0][CNT_W-1:0]  cnt_q;
  fetch_tgt_e                     tgt_q;
  logic [8:0]                     region_q;
  logic [31:0]                    mask_q;
  logic                           trap_q;
  logic                           fault_q;

  // named internal events for the checker
  logic dec_fault;
  logic hold_counts;
  logic zero_counts;

  fetch_target_decode #(
    .ADDR_W(ADDR_W), .IRAM_BYTES(IRAM_BYTES), .MAIN_BYTES(MAIN_BYTES),
    .PRIV_BYTES(PRIV_BYTES), .ROM_BYTES(ROM_BYTES), .TCM_GRAIN(TCM_GRAIN),
    .SHARED_GRAIN(SHARED_GRAIN)
  ) u_dec (
    .addr_i(br_addr), .main_mode_i(main_mode), .rom_present_i(rom_present),
    .tcm_vsize_i(tcm_vsize), .shared_sel_i(shared_sel), .dec_o(dec)
  );

  fetch_wait_lookup #(.CNT_W(CNT_W)) u_wait (
    .region_i(br_addr[ADDR_W-1 -: 8]), .main_mode_i(main_mode), .cnt_o(lookup)
  );

  assign dec_fault   = br_valid && dec.fault;
  assign hold_counts = dec_fault && dec.keep_counts;
  assign zero_counts = dec_fault && !dec.keep_counts;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q    <= TGT_NONE;
      region_q <= '0;
      mask_q   <= '0;
      trap_q   <= 1'b0;
      fault_q  <= 1'b0;
      cnt_q    <= '0;
    end else if (br_valid) begin
      tgt_q    <= dec.tgt;
      region_q <= dec.region;
      mask_q   <= dec.mask;
      trap_q   <= dec.trap;
      fault_q  <= dec.fault;
      if (zero_counts)       cnt_q <= '0;
      else if (!hold_counts) cnt_q <= lookup;
    end else begin
      fault_q  <= 1'b0;
    end
  end

  assign fetch_target = tgt_q;
  assign fetch_region = region_q;
  assign fetch_mask   = mask_q;
  assign trap_fetch   = trap_q;
  assign trap_opcode  = trap_q ? TRAP_WORD : 32'd0;
  assign jump_fault   = fault_q;
  assign wait_nseq16  = cnt_q[K_NSEQ16];
  assign wait_seq16   = cnt_q[K_SEQ16];
  assign wait_nseq32  = cnt_q[K_NSEQ32];
  assign wait_seq32   = cnt_q[K_SEQ32];
endmodule

// File: rtl/fetch_region_tracker_chk.sv
module fetch_region_tracker_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             br_valid,
  input logic             main_mode,
  input logic             dec_fault,
  input logic             hold_counts,
  input logic [2:0]       fetch_target,
  input logic [8:0]       fetch_region,
  input logic [31:0]      fetch_mask,
  input logic             trap_fetch,
  input logic [31:0]      trap_opcode,
  input logic             jump_fault,
  input logic [CNT_W-1:0] wait_nseq16,
  input logic [CNT_W-1:0] wait_seq16,
  input logic [CNT_W-1:0] wait_nseq32,
  input logic [CNT_W-1:0] wait_seq32
);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |=> $stable(fetch_region) && $stable(fetch_mask) && $stable(fetch_target)
                  && $stable(wait_nseq16) && $stable(wait_seq32));

  a_r7_fault_needs_branch: assert property (@(posedge clk) disable iff (!rst_n)
    jump_fault |-> $past(br_valid));

  a_r7_fault_state: assert property (@(posedge clk) disable iff (!rst_n)
    jump_fault |-> fetch_region == 9'h1FF && fetch_mask == 32'd0 && trap_fetch);

  a_r6_trap_mask: assert property (@(posedge clk) disable iff (!rst_n)
    trap_fetch |-> fetch_mask == 32'd0 && fetch_target == 3'd6);

  a_r8_opcode: assert property (@(posedge clk) disable iff (!rst_n)
    trap_fetch |-> trap_opcode == 32'hE710B710);

  a_r9_seq_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && main_mode && !dec_fault) |=>
      wait_seq16 == wait_nseq16 && wait_seq32 == wait_nseq32);

  a_r11_main_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hold_counts |=> $stable(wait_nseq16) && $stable(wait_seq16)
                    && $stable(wait_nseq32) && $stable(wait_seq32));

  a_r11_sub_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_fault && !main_mode) |=> wait_nseq16 == 0 && wait_seq16 == 0
                                  && wait_nseq32 == 0 && wait_seq32 == 0);
endmodule

bind fetch_region_tracker fetch_region_tracker_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .main_mode(main_mode),
  .dec_fault(dec_fault), .hold_counts(hold_counts),
  .fetch_target(fetch_target), .fetch_region(fetch_region), .fetch_mask(fetch_mask),
  .trap_fetch(trap_fetch), .trap_opcode(trap_opcode), .jump_fault(jump_fault),
  .wait_nseq16(wait_nseq16), .wait_seq16(wait_seq16),
  .wait_nseq32(wait_nseq32), .wait_seq32(wait_seq32)
);

// File: tb/sim_fetch_region_tracker.sv
`timescale 1ns/1ps
module sim_fetch_region_tracker;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        br_valid = 1'b0;
  logic [31:0] br_addr = '0;
  logic        main_mode = 1'b0;
  logic        rom_present = 1'b1;
  logic [4:0]  tcm_vsize = 5'd5;
  logic [1:0]  shared_sel = 2'd0;
  logic [2:0]  fetch_target;
  logic [8:0]  fetch_region;
  logic [31:0] fetch_mask;
  logic        trap_fetch;
  logic [31:0] trap_opcode;
  logic        jump_fault;
  logic [4:0]  wait_nseq16, wait_seq16, wait_nseq32, wait_seq32;

  fetch_region_tracker u0 (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_addr(br_addr),
    .main_mode(main_mode), .rom_present(rom_present), .tcm_vsize(tcm_vsize),
    .shared_sel(shared_sel), .fetch_target(fetch_target), .fetch_region(fetch_region),
    .fetch_mask(fetch_mask), .trap_fetch(trap_fetch), .trap_opcode(trap_opcode),
    .jump_fault(jump_fault), .wait_nseq16(wait_nseq16), .wait_seq16(wait_seq16),
    .wait_nseq32(wait_nseq32), .wait_seq32(wait_seq32)
  );

  always #(PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";
  bit done = 0;

  // reference tables (index = region byte)
  int mn16 [8] = '{6,6,17,6,6,7,7,6};
  int mn32 [8] = '{6,6,19,6,6,9,9,6};
  int sn16 [8] = '{0,0,8,0,0,0,0,0};
  int sn32 [8] = '{0,0,9,0,0,1,1,0};
  int ss16 [8] = '{0,0,1,0,0,0,0,0};
  int ss32 [8] = '{0,0,2,0,0,1,1,0};

  // model state
  int m_tgt = 0, m_region = 0, m_n16 = 0, m_s16 = 0, m_n32 = 0, m_s32 = 0;
  longint m_mask = 0;
  bit m_trap = 0, m_fault = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin : model
    int rg;
    bit err;
    if (!rst_n) begin
      m_tgt = 0; m_region = 0; m_mask = 0; m_trap = 0; m_fault = 0;
      m_n16 = 0; m_s16 = 0; m_n32 = 0; m_s32 = 0;
    end else if (!br_valid) begin
      m_fault = 0;
    end else begin
      rg = int'(br_addr[31:24]);
      err = 0;
      m_trap = 0;
      if (main_mode) begin
        if ((rg == 0 || rg == 1) && (longint'(br_addr) < (longint'(512) << tcm_vsize))) begin
          m_tgt = 1; m_mask = 32'h7FFF;
        end else if (rg == 2) begin
          m_tgt = 2; m_mask = 32'h3FFFFF;
        end else if (rg == 255) begin
          if (rom_present) begin m_tgt = 5; m_mask = 32'hFFF; end
          else begin m_tgt = 6; m_mask = 0; m_trap = 1; end
        end else err = 1;
      end else begin
        if (rg == 0) begin
          if (rom_present) begin m_tgt = 5; m_mask = 32'hFFF; end
          else begin m_tgt = 6; m_mask = 0; m_trap = 1; end
        end else if (rg == 2) begin
          m_tgt = 2; m_mask = 32'h3FFFFF;
        end else if (rg == 3) begin
          if (br_addr >= 32'h0380_0000 || shared_sel == 0) begin m_tgt = 3; m_mask = 32'hFFFF; end
          else begin m_tgt = 4; m_mask = (longint'(8192) << shared_sel) - 1; end
        end else err = 1;
      end
      m_fault = err;
      if (err) begin
        m_tgt = 6; m_mask = 0; m_trap = 1; m_region = 'h1FF;
        if (!main_mode) begin m_n16 = 0; m_s16 = 0; m_n32 = 0; m_s32 = 0; end
      end else begin
        m_region = rg;
        if (rg >= 8) begin m_n16 = 0; m_s16 = 0; m_n32 = 0; m_s32 = 0; end
        else if (main_mode) begin
          m_n16 = mn16[rg]; m_s16 = mn16[rg]; m_n32 = mn32[rg]; m_s32 = mn32[rg];
        end else begin
          m_n16 = sn16[rg]; m_s16 = ss16[rg]; m_n32 = sn32[rg]; m_s32 = ss32[rg];
        end
      end
    end
  end

  // every-cycle comparison, half a cycle after the loading edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, "target", fetch_target, m_tgt);
      chk(cur_req, "region", fetch_region, m_region);
      chk(cur_req, "mask", fetch_mask, m_mask);
      chk(cur_req, "trap", trap_fetch, m_trap);
      chk("R8", "opcode", trap_opcode, m_trap ? 32'hE710B710 : 0);
      chk("R7", "fault", jump_fault, m_fault);
      chk(cur_req, "nseq16", wait_nseq16, m_n16);
      chk(cur_req, "seq16", wait_seq16, m_s16);
      chk(cur_req, "nseq32", wait_nseq32, m_n32);
      chk(cur_req, "seq32", wait_seq32, m_s32);
    end
  end

  task automatic jump(input string req, input logic [31:0] a);
    @(negedge clk);
    cur_req = req;
    br_valid = 1'b1; br_addr = a;
    @(negedge clk);
    br_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic jump_pair(input string req, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    cur_req = req;
    br_valid = 1'b1; br_addr = a;
    @(negedge clk);
    br_addr = b;
    @(negedge clk);
    br_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    #(PERIOD * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values held during reset
    chk("R1", "reset target", fetch_target, 0);
    chk("R1", "reset mask", fetch_mask, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "post-reset region", fetch_region, 0);
    chk("R1", "post-reset counts", wait_nseq32, 0);

    // secondary core
    main_mode = 1'b0;
    jump("R10", 32'h0200_0100);
    jump("R3", 32'h0200_0000);
    rom_present = 1'b1;
    jump("R6", 32'h0000_0040);
    rom_present = 1'b0;
    jump("R6", 32'h0000_0040);
    rom_present = 1'b1;
    shared_sel = 2'd0;
    jump("R5", 32'h0300_0010);
    shared_sel = 2'd2;
    jump("R5", 32'h0300_0010);
    shared_sel = 2'd1;
    jump("R5", 32'h037F_FFFC);
    jump("R5", 32'h0380_0004);
    jump("R10", 32'h0200_0000);
    jump("R11", 32'h0500_0000);
    jump("R7", 32'h0100_0000);
    jump_pair("R7", 32'h0600_0000, 32'h0700_0000);
    jump_pair("R2", 32'h0200_0000, 32'h0300_0000);

    // main core
    main_mode = 1'b1;
    tcm_vsize = 5'd5;
    jump("R4", 32'h0000_3FFC);
    jump("R9", 32'h0200_0000);
    jump("R11", 32'h0000_4000);
    jump("R7", 32'h0300_0000);
    tcm_vsize = 5'd15;
    jump("R4", 32'h0100_0000);
    tcm_vsize = 5'd16;
    jump("R4", 32'h0100_0000);
    rom_present = 1'b1;
    jump("R6", 32'hFF00_0000);
    rom_present = 1'b0;
    jump("R6", 32'hFFFF_0000);
    jump("R9", 32'h0000_0000);
    jump_pair("R11", 32'h0500_0000, 32'h0400_0000);
    jump_pair("R2", 32'h0200_0000, 32'h0100_0000);
    // config change without a strobe must not move outputs
    cur_req = "R2";
    main_mode = 1'b0; rom_present = 1'b1; shared_sel = 2'd3;
    repeat (3) @(negedge clk);
    done = 1;
    chk("R2", "hold region", fetch_region, m_region);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule